// File: doc/BRIEF.md
# Local Variable and Branch Sequencer

This block carries out the local-variable and control-transfer operations of a stack-based bytecode machine. The front end has already consumed the opcode byte. It hands over the operation code together with the current program counter, frame base, stack pointer and cached top-of-stack value. The block then works through its own short sequence of steps. It reads operand bytes through a program memory port and reads and writes words through a single stack memory port. When it finishes, it returns the updated program counter, stack pointer and top-of-stack value with a one-cycle completion pulse.

A local variable lives in the stack memory at the frame base plus four times an unsigned byte index. Loads push a variable, stores pop into one, and the increment form adds a signed byte constant in place. The increment form also keeps the cached top-of-stack value coherent when the variable it touches is the current top slot. Conditional branches test the cached top value, or compare the two top entries, and then pop. A branch that is taken loads a 16-bit absolute target. A branch that is not taken steps over its two operand bytes. The unconditional jump loads the same kind of target.

The stack memory port has a combinational read and a write that takes effect at the clock edge. The program port returns two bytes, big-endian: the byte at the presented address sits in the upper half. Stack addresses are byte addresses, and each word slot is 4 bytes.

Top module: `lvbr_unit`

## Requirements
- R1: After reset, busy_o, done_o and stk_we_o are 0, and pc_o, sp_o and tos_o are 0.
- R2: The operand half-word is read at prog_addr_o = pc (low PROG_AW bits). Its upper byte is an unsigned index n, and the variable address is lv + 4*n.
- R3: Load (op 0) reads the variable, writes its value to the stack at sp+4, and returns sp+4, tos = value and pc+1.
- R4: Store (op 1) writes the incoming tos to the variable, pops one entry (sp-4) and returns pc+1.
- R5: Increment (op 2) adds the sign-extended lower operand byte to the variable and returns pc+2 with sp unchanged. tos becomes the new value when the variable address equals sp, and is otherwise unchanged.
- R6: Branch-if-zero (op 3) tests tos == 0 and branch-if-negative (op 4) tests bit 31 of tos. Both pop one entry. A taken branch returns pc = the zero-extended operand half-word; an untaken one returns pc+2.
- R7: Branch-if-equal (op 5) compares the stack word at sp-4 with tos and pops two entries (sp-8). pc follows the rule of R6.
- R8: Jump (op 6) returns pc = the zero-extended operand half-word, leaves sp and tos unchanged and writes no stack word.
- R9: After every pop (ops 1, 3, 4, 5), tos is reloaded from the stack word at the new sp only when that sp is non-negative as a signed value. Otherwise tos keeps its incoming value.
- R10: start_i is accepted only while busy_o is 0. done_o is high for exactly one cycle, after which busy_o falls. start_i pulses while busy have no effect on the result.
- R11: Op code 7 is a no-operation. It completes with pc, sp and tos unchanged and no stack write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation with the values on the other inputs |
| op_i | input | 3 | Operation code (see requirements) |
| pc_i | input | 32 | Program counter, pointing at the first operand byte |
| lv_i | input | 32 | Frame base byte address |
| sp_i | input | 32 | Stack pointer, byte address of the top slot |
| tos_i | input | 32 | Cached top-of-stack value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse; results valid |
| pc_o | output | 32 | Resulting program counter |
| sp_o | output | 32 | Resulting stack pointer |
| tos_o | output | 32 | Resulting top-of-stack value |
| prog_addr_o | output | PROG_AW | Program memory byte address |
| prog_half_i | input | 16 | Bytes at prog_addr_o and prog_addr_o+1, first byte in the upper half |
| stk_addr_o | output | 32 | Stack memory byte address |
| stk_we_o | output | 1 | Stack write strobe |
| stk_wdata_o | output | 32 | Stack write data |
| stk_rdata_i | input | 32 | Stack read data for stk_addr_o (combinational) |

## Verification
Random operations run over random program bytes, frame bases, stack pointers and top values. Zero tops are forced often enough that both the zero and non-zero branch paths occur. The equal comparison is made true by planting tos one slot below the top. Directed cases cover a stack pointer of 0 or 4, which shows whether the reload after a pop is skipped for a negative pointer. An increment whose variable aliases the top slot separates the coherent tos update from a stale one, and a constant byte of 0xFF exposes a missing sign extension. Start pulses issued mid-operation show whether a busy unit wrongly relatches its inputs.

// File: rtl/lvbr_pkg.sv
`timescale 1ns/1ps
package lvbr_pkg;
  localparam int WORD_W  = 32;
  localparam int OPND_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int SLOT_SH = 2;
  localparam int STEP    = 1 << SLOT_SH;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [OPND_W-1:0] opnd_t;

  typedef enum logic [2:0] {
    OP_ILOAD  = 3'd0,
    OP_ISTORE = 3'd1,
    OP_IINC   = 3'd2,
    OP_IFEQ   = 3'd3,
    OP_IFLT   = 3'd4,
    OP_ICMPEQ = 3'd5,
    OP_GOTO   = 3'd6,
    OP_NONE   = 3'd7
  } lv_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXEC, ST_VAR, ST_WRITE, ST_RELOAD, ST_DONE
  } seq_st_e;

  // frame slot address: base plus index times slot size
  function automatic word_t slot_addr(word_t base, byte_t idx);
    return base + (word_t'(idx) << SLOT_SH);
  endfunction

  function automatic word_t sext_byte(byte_t b);
    return {{(WORD_W-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction

  function automatic word_t zext_opnd(opnd_t h);
    return {{(WORD_W-OPND_W){1'b0}}, h};
  endfunction

  function automatic logic cond_hold(lv_op_e op, word_t top, word_t below);
    case (op)
      OP_IFEQ:   return top == '0;
      OP_IFLT:   return top[WORD_W-1];
      OP_ICMPEQ: return (below - top) == '0;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic is_pop(lv_op_e op);
    return op == OP_ISTORE || op == OP_IFEQ || op == OP_IFLT || op == OP_ICMPEQ;
  endfunction
endpackage

// File: rtl/lvbr_operand.sv
`timescale 1ns/1ps
module lvbr_operand
  import lvbr_pkg::*;
(
  input  opnd_t opnd_i,
  input  word_t lv_i,
  output word_t var_addr_o,
  output word_t inc_o,
  output word_t target_o
);
  localparam int IDX_HI = OPND_W - 1;
  localparam int IDX_LO = OPND_W - BYTE_W;

  byte_t idx_b, const_b;
  assign idx_b   = opnd_i[IDX_HI:IDX_LO];
  assign const_b = opnd_i[IDX_LO-1:0];

  assign var_addr_o = slot_addr(lv_i, idx_b);
  assign inc_o      = sext_byte(const_b);
  assign target_o   = zext_opnd(opnd_i);
endmodule

// File: rtl/lvbr_cond.sv
`timescale 1ns/1ps
module lvbr_cond
  import lvbr_pkg::*;
(
  input  lv_op_e op_i,
  input  word_t  top_i,
  input  word_t  below_i,
  output logic   taken_o
);
  assign taken_o = cond_hold(op_i, top_i, below_i);
endmodule

// File: rtl/lvbr_seq.sv
`timescale 1ns/1ps
module lvbr_seq
  import lvbr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  lv_op_e op_i,
  input  word_t  pc_i,
  input  word_t  lv_i,
  input  word_t  sp_i,
  input  word_t  tos_i,
  input  word_t  var_addr_i,
  input  word_t  inc_i,
  input  word_t  target_i,
  input  logic   taken_i,
  output lv_op_e op_o,
  output word_t  pc_o,
  output word_t  lv_o,
  output word_t  sp_o,
  output word_t  tos_o,
  output logic   busy_o,
  output logic   done_o,
  output word_t  stk_addr_o,
  output logic   stk_we_o,
  output word_t  stk_wdata_o,
  input  word_t  stk_rdata_i
);
  seq_st_e st_q;
  lv_op_e  op_q;
  word_t   pc_q, lv_q, sp_q, tos_q, va_q, data_q;

  // named internal events
  logic  pop_evt, push_evt, tos_hit, reload_ok;
  word_t br_pc;
  assign pop_evt   = (st_q == ST_EXEC) && is_pop(op_q);
  assign push_evt  = (st_q == ST_WRITE) && (op_q == OP_ILOAD);
  assign tos_hit   = (st_q == ST_WRITE) && (op_q == OP_IINC) && (va_q == sp_q);
  assign reload_ok = (st_q == ST_RELOAD) && !sp_q[WORD_W-1];
  assign br_pc     = taken_i ? target_i : pc_q + word_t'(2);

  always_comb begin
    stk_addr_o  = sp_q;
    stk_we_o    = 1'b0;
    stk_wdata_o = tos_q;
    case (st_q)
      ST_EXEC: begin
        if (op_q == OP_ISTORE) begin
          stk_addr_o = var_addr_i;
          stk_we_o   = 1'b1;
        end else if (op_q == OP_ICMPEQ) begin
          stk_addr_o = sp_q - word_t'(STEP);
        end
      end
      ST_VAR:   stk_addr_o = va_q;
      ST_WRITE: begin
        stk_we_o    = 1'b1;
        stk_wdata_o = data_q;
        stk_addr_o  = (op_q == OP_ILOAD) ? sp_q + word_t'(STEP) : va_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_NONE;
      pc_q   <= '0;
      lv_q   <= '0;
      sp_q   <= '0;
      tos_q  <= '0;
      va_q   <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          op_q  <= op_i;
          pc_q  <= pc_i;
          lv_q  <= lv_i;
          sp_q  <= sp_i;
          tos_q <= tos_i;
          st_q  <= ST_EXEC;
        end
        ST_EXEC: begin
          case (op_q)
            OP_ILOAD, OP_IINC: begin
              va_q <= var_addr_i;
              st_q <= ST_VAR;
            end
            OP_ISTORE: begin
              pc_q <= pc_q + word_t'(1);
              sp_q <= sp_q - word_t'(STEP);
              st_q <= ST_RELOAD;
            end
            OP_IFEQ, OP_IFLT: begin
              pc_q <= br_pc;
              sp_q <= sp_q - word_t'(STEP);
              st_q <= ST_RELOAD;
            end
            OP_ICMPEQ: begin
              pc_q <= br_pc;
              sp_q <= sp_q - word_t'(2*STEP);
              st_q <= ST_RELOAD;
            end
            OP_GOTO: begin
              pc_q <= target_i;
              st_q <= ST_DONE;
            end
            default: st_q <= ST_DONE;
          endcase
        end
        ST_VAR: begin
          data_q <= (op_q == OP_IINC) ? stk_rdata_i + inc_i : stk_rdata_i;
          st_q   <= ST_WRITE;
        end
        ST_WRITE: begin
          if (push_evt) begin
            sp_q  <= sp_q + word_t'(STEP);
            tos_q <= data_q;
            pc_q  <= pc_q + word_t'(1);
          end else begin
            pc_q <= pc_q + word_t'(2);
            if (tos_hit) tos_q <= data_q;
          end
          st_q <= ST_DONE;
        end
        ST_RELOAD: begin
          if (reload_ok) tos_q <= stk_rdata_i;
          st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign op_o   = op_q;
  assign pc_o   = pc_q;
  assign lv_o   = lv_q;
  assign sp_o   = sp_q;
  assign tos_o  = tos_q;
  assign busy_o = st_q != ST_IDLE;
  assign done_o = st_q == ST_DONE;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  hold_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(op_q));
  // R6
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && (op_q == OP_IFEQ || op_q == OP_IFLT)) |=> sp_q == $past(sp_q) - word_t'(STEP));
  // R7
  pop_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && op_q == OP_ICMPEQ) |=> sp_q == $past(sp_q) - word_t'(2*STEP));
  // R8
  goto_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (op_q == OP_GOTO || op_q == OP_NONE)) |-> !stk_we_o);
  // R9
  reload_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RELOAD && sp_q[WORD_W-1]) |=> $stable(tos_q));
  // R3
  push_tos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> tos_q == $past(stk_wdata_o));
endmodule

// File: rtl/lvbr_unit.sv
`timescale 1ns/1ps
module lvbr_unit
  import lvbr_pkg::*;
#(
  parameter int PROG_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [2:0]         op_i,
  input  logic [31:0]        pc_i,
  input  logic [31:0]        lv_i,
  input  logic [31:0]        sp_i,
  input  logic [31:0]        tos_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [31:0]        pc_o,
  output logic [31:0]        sp_o,
  output logic [31:0]        tos_o,
  output logic [PROG_AW-1:0] prog_addr_o,
  input  logic [15:0]        prog_half_i,
  output logic [31:0]        stk_addr_o,
  output logic               stk_we_o,
  output logic [31:0]        stk_wdata_o,
  input  logic [31:0]        stk_rdata_i
);
  lv_op_e op_cur;
  word_t  lv_cur, var_addr, inc_val, target;
  logic   taken;

  lvbr_operand u_opnd (
    .opnd_i     (prog_half_i),
    .lv_i       (lv_cur),
    .var_addr_o (var_addr),
    .inc_o      (inc_val),
    .target_o   (target)
  );

  lvbr_cond u_cond (
    .op_i    (op_cur),
    .top_i   (tos_o),
    .below_i (stk_rdata_i),
    .taken_o (taken)
  );

  lvbr_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .op_i        (lv_op_e'(op_i)),
    .pc_i        (pc_i),
    .lv_i        (lv_i),
    .sp_i        (sp_i),
    .tos_i       (tos_i),
    .var_addr_i  (var_addr),
    .inc_i       (inc_val),
    .target_i    (target),
    .taken_i     (taken),
    .op_o        (op_cur),
    .pc_o        (pc_o),
    .lv_o        (lv_cur),
    .sp_o        (sp_o),
    .tos_o       (tos_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .stk_addr_o  (stk_addr_o),
    .stk_we_o    (stk_we_o),
    .stk_wdata_o (stk_wdata_o),
    .stk_rdata_i (stk_rdata_i)
  );

  assign prog_addr_o = pc_o[PROG_AW-1:0];
endmodule

// File: tb/lvbr_unit_tb.sv
`timescale 1ns/1ps
module lvbr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] pc_i = '0, lv_i = '0, sp_i = '0, tos_i = '0;
  logic        busy_o, done_o, stk_we_o;
  logic [31:0] pc_o, sp_o, tos_o, stk_addr_o, stk_wdata_o, stk_rdata_i;
  logic [6:0]  prog_addr_o;
  logic [15:0] prog_half_i;

  logic [7:0]  pmem [128];
  logic [31:0] smem [64];
  logic [31:0] emem [64];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  lvbr_unit u_dut (.*);

  always @(posedge clk) if (stk_we_o) smem[stk_addr_o[7:2]] <= stk_wdata_o;
  assign stk_rdata_i = smem[stk_addr_o[7:2]];
  assign prog_half_i = {pmem[prog_addr_o], pmem[prog_addr_o + 7'd1]};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3, 4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R11";
    endcase
  endfunction

  // expected results from the requirement text
  task automatic model(int op, logic [31:0] pc, lv, sp, tos,
                       output logic [31:0] epc, esp, etos);
    logic [15:0] h;
    logic [31:0] va, nv, tgt;
    logic taken;
    h   = {pmem[pc[6:0]], pmem[pc[6:0] + 7'd1]};
    va  = lv + {22'd0, h[15:8], 2'b00};
    tgt = {16'd0, h};
    epc = pc; esp = sp; etos = tos; taken = 1'b0;
    case (op)
      0: begin nv = emem[va[7:2]]; esp = sp + 4; emem[esp[7:2]] = nv; etos = nv; epc = pc + 1; end
      1: begin emem[va[7:2]] = tos; esp = sp - 4; epc = pc + 1; end
      2: begin
        nv = emem[va[7:2]] + {{24{h[7]}}, h[7:0]};
        emem[va[7:2]] = nv; epc = pc + 2;
        if (va == sp) etos = nv;
      end
      3, 4, 5: begin
        if (op == 3) taken = (tos == 0);
        else if (op == 4) taken = tos[31];
        else taken = (emem[(sp - 32'd4) >> 2 & 32'h3f] == tos);
        esp = sp - ((op == 5) ? 32'd8 : 32'd4);
        epc = taken ? tgt : pc + 2;
      end
      6: epc = tgt;
      default: ;
    endcase
    // R9: reload after pops only for non-negative sp
    if ((op == 1 || op == 3 || op == 4 || op == 5) && !esp[31]) etos = emem[esp[7:2]];
  endtask

  task automatic run_op(int op, logic [31:0] pc, lv, sp, tos, bit poke);
    logic [31:0] epc, esp, etos;
    int n, mism;
    string t;
    for (int i = 0; i < 64; i++) emem[i] = smem[i];
    model(op, pc, lv, sp, tos, epc, esp, etos);
    t = tag_of(op);
    @(negedge clk);
    start_i = 1'b1; op_i = 3'(op); pc_i = pc; lv_i = lv; sp_i = sp; tos_i = tos;
    @(negedge clk);
    if (poke) begin
      start_i = 1'b1; op_i = 3'(6); pc_i = 32'h40; sp_i = 32'h10; tos_i = 32'h5;
    end else start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 40) begin @(negedge clk); n++; end
    chk("R10 done seen", {31'd0, done_o}, 32'd1);
    chk(t, pc_o, epc);
    chk(t, sp_o, esp);
    chk((op == 1 || (op >= 3 && op <= 5)) ? "R9" : t, tos_o, etos);
    @(negedge clk);
    chk("R10 done width", {31'd0, done_o}, 32'd0);
    chk("R10 idle after", {31'd0, busy_o}, 32'd0);
    mism = 0;
    for (int i = 0; i < 64; i++) if (smem[i] !== emem[i]) mism++;
    chk((op <= 2) ? "R2 stack image" : t, mism, 0);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed_v;
    logic [31:0] sp, lv, tos, pc;
    int op;
    seed_v = int'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) pmem[i] = 8'($urandom);
    for (int i = 0; i < 64; i++) smem[i] = $urandom;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy_o}, 0);
    chk("R1 done", {31'd0, done_o}, 0);
    chk("R1 we", {31'd0, stk_we_o}, 0);
    chk("R1 pc", pc_o, 0);
    chk("R1 sp", sp_o, 0);
    chk("R1 tos", tos_o, 0);
    rst_n = 1'b1;

    // R3 load, index 5
    pmem[10] = 8'd5; run_op(0, 32'd10, 32'd16, 32'd100, 32'h1234, 0);
    // R4 store with reload, and with sp 0 (no reload, R9)
    pmem[20] = 8'd3; run_op(1, 32'd20, 32'd0, 32'd60, 32'hCAFE, 0);
    pmem[21] = 8'd7; run_op(1, 32'd21, 32'd8, 32'd0, 32'hBEEF, 0);
    // R5 negative constant, then aliased top slot
    pmem[30] = 8'd2; pmem[31] = 8'hFF; run_op(2, 32'd30, 32'd40, 32'd120, 32'h77, 0);
    pmem[32] = 8'd4; pmem[33] = 8'h05; run_op(2, 32'd32, 32'd64, 32'd80, 32'h99, 0);
    // R6 taken / not taken
    run_op(3, 32'd40, 32'd0, 32'd44, 32'd0, 0);
    run_op(3, 32'd40, 32'd0, 32'd44, 32'd9, 0);
    run_op(4, 32'd42, 32'd0, 32'd4, 32'hFFFF_FFF0, 0);
    // R7 equal at sp 4 (pops to negative, R9), and unequal
    smem[0] = 32'h55; run_op(5, 32'd50, 32'd0, 32'd4, 32'h55, 0);
    smem[9] = 32'h56; run_op(5, 32'd50, 32'd0, 32'd40, 32'h55, 0);
    // R8 jump, R11 no-op
    pmem[60] = 8'h00; pmem[61] = 8'h7C; run_op(6, 32'd60, 32'd0, 32'd20, 32'h1, 0);
    run_op(7, 32'd61, 32'd4, 32'd24, 32'h2, 0);
    // R10 start while busy ignored
    pmem[70] = 8'd1; run_op(0, 32'd70, 32'd0, 32'd32, 32'h3, 1);
    run_op(6, 32'd60, 32'd0, 32'd20, 32'h1, 1);

    for (int k = 0; k < 300; k++) begin
      op  = $urandom_range(0, 7);
      pc  = $urandom_range(0, 123);
      lv  = {$urandom_range(0, 31), 2'b00};
      sp  = ($urandom_range(0, 5) == 0) ? {30'd0, 1'b0, 1'($urandom)} << 2 : {$urandom_range(0, 63), 2'b00};
      tos = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
      pmem[pc[6:0]] = 8'($urandom_range(0, 31));
      pmem[pc[6:0] + 7'd1] = 8'($urandom);
      if (op == 2 && $urandom_range(0, 2) == 0) begin
        lv = {$urandom_range(0, 15), 2'b00};
        sp = lv + {22'd0, pmem[pc[6:0]], 2'b00};
      end
      if (op == 5 && $urandom_range(0, 1) == 0) smem[(sp - 32'd4) >> 2 & 32'h3f] = tos;
      run_op(op, pc, lv, sp, tos, k % 17 == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule